// File: doc/BRIEF.md
# Radio byte data port controller

This block sits between a processor bus and the byte stream of a packet radio and holds exactly one byte. It serves both directions. In receive mode the radio side drops each incoming byte into the holding register, and software or a DMA channel reads it from there. In transmit mode software or DMA loads the register, and the radio side takes the byte when it asks for one. A byte-valid bit records whether the register holds data that has not yet been used.

When software falls behind, the block moves into a sticky error state. A receive byte that arrives on top of an unread one gives receive overflow. A transmit request that finds no byte gives transmit underflow. Each error raises its own flag and also the packet-done flag. The block then freezes and moves no data until an idle strobe arrives.

Eight sticky interrupt flags are gated by an eight-bit enable mask and combined into one interrupt line. A one-cycle DMA trigger pulse marks each received byte that is ready to be moved.

Top module: `radio_byte_port`

## Requirements
- R1: `bus_rdata` always shows the held byte. In receive state (code 1), `radio_rx_valid` loads `radio_rx_data` and sets `byte_valid`. A `bus_rd_en` with no delivery in the same cycle clears `byte_valid`. A delivery in the same cycle as a read is accepted.
- R2: In transmit state (code 2), `bus_wr_en` loads `bus_wdata` and sets `byte_valid`. `radio_tx_data` always shows the held byte. A `radio_tx_req` while `byte_valid` is set consumes the byte and clears `byte_valid`, unless a bus write in the same cycle loads a new byte.
- R3: In receive state, a delivery while `byte_valid` is set and no read occurs moves the state to receive-overflow (code 3). It also sets flag bit 6 and flag bit 4. The held byte is not changed.
- R4: In transmit state, a `radio_tx_req` while `byte_valid` is clear moves the state to transmit-underflow (code 4). It also sets flag bit 7 and flag bit 4. A bus write in that same cycle is dropped.
- R5: In either error state the following have no effect: radio deliveries, radio requests, bus writes, and the rx and tx strobes. The state holds until `strobe_idle`, which moves it to idle (code 0) and clears `byte_valid`.
- R6: The mask resets to 0 and is loaded by `mask_wr_en`. Bit order from 7 down to 0 is: tx underflow, rx overflow, rx timeout, done, carrier sense, preamble quality, clear channel, sync word. `irq` is the OR over all bits of flag AND mask.
- R7: Flags are sticky. They are set by internal errors or by `src_evt` bits. `flag_clr_en` clears every bit where `flag_clr_data` is 0. A set in the same cycle wins over a clear.
- R8: `dma_trig` is high for exactly the one cycle that follows the clock edge that accepted a received byte.
- R9: `pwr_down` clears the held byte to 0 and clears `byte_valid`. While it is high, no transfer and no error event takes place.
- R10: From idle, receive or transmit, `strobe_rx` selects receive and `strobe_tx` selects transmit. `strobe_rx` wins over `strobe_tx`, `strobe_idle` wins over both, and an error event in the same cycle wins over either mode strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Retention loss, clears the held byte |
| bus_wr_en | input | 1 | Bus write of the data register |
| bus_wdata | input | 8 | Byte to transmit |
| bus_rd_en | input | 1 | Bus read of the data register |
| bus_rdata | output | 8 | Held byte |
| mask_wr_en | input | 1 | Mask register write |
| mask_wdata | input | 8 | New mask value |
| flag_clr_en | input | 1 | Flag register write |
| flag_clr_data | input | 8 | Flag bits written as 0 are cleared |
| strobe_rx | input | 1 | Enter receive state |
| strobe_tx | input | 1 | Enter transmit state |
| strobe_idle | input | 1 | Return to idle, leave error |
| radio_rx_valid | input | 1 | Radio delivers a byte |
| radio_rx_data | input | 8 | Delivered byte |
| radio_tx_req | input | 1 | Radio takes a byte |
| radio_tx_data | output | 8 | Byte offered to the radio |
| src_evt | input | 8 | External flag set pulses |
| state | output | 3 | Mode code 0 to 4 |
| byte_valid | output | 1 | Register occupancy |
| flags | output | 8 | Interrupt flags |
| mask | output | 8 | Interrupt enable mask |
| irq | output | 1 | Combined interrupt |
| dma_trig | output | 1 | Received-byte DMA trigger |

## Verification
The data-freeze check assumes that power-down is the only path that changes the held byte while the block is in an error state. The error-state hold check assumes the idle strobe is the only way out. Both checks exempt exactly those inputs, and the stimulus exercises them freely.

All inputs are driven a few time units after a rising edge, so every value is settled and known at the next edge. In the random phase, idle strobes and power-down pulses are kept rare. As a result, error states and full registers last for many cycles, and deliveries, requests and bus writes hit them repeatedly.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  localparam int FLAG_W   = 8;
  localparam int B_TXUNF  = 7;
  localparam int B_RXOVF  = 6;
  localparam int B_DONE   = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RX     = 3'd1,
    ST_TX     = 3'd2,
    ST_RX_OVF = 3'd3,
    ST_TX_UNF = 3'd4
  } rbp_state_e;

  function automatic logic is_error(input rbp_state_e s);
    return (s == ST_RX_OVF) || (s == ST_TX_UNF);
  endfunction

  function automatic logic [FLAG_W-1:0] flag_next(
    input logic [FLAG_W-1:0] cur,
    input logic              clr_en,
    input logic [FLAG_W-1:0] keep,
    input logic [FLAG_W-1:0] set
  );
    logic [FLAG_W-1:0] kept;
    kept = clr_en ? (cur & keep) : cur;
    return kept | set;
  endfunction

  function automatic logic irq_reduce(
    input logic [FLAG_W-1:0] f,
    input logic [FLAG_W-1:0] m
  );
    return |(f & m);
  endfunction
endpackage

// File: rtl/rbp_mode_fsm.sv
module rbp_mode_fsm
  import rbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_rx,
  input  logic       strobe_tx,
  input  logic       strobe_idle,
  input  logic       ev_ovf,
  input  logic       ev_unf,
  output rbp_state_e state_q
);
  rbp_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (strobe_idle)          state_d = ST_IDLE;
    else if (ev_ovf)          state_d = ST_RX_OVF;
    else if (ev_unf)          state_d = ST_TX_UNF;
    else if (!is_error(state_q)) begin
      if (strobe_rx)          state_d = ST_RX;
      else if (strobe_tx)     state_d = ST_TX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_ovf_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> state_q == ST_RX_OVF);
  assert_unf_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> state_q == ST_TX_UNF);
  assert_error_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_error(state_q) && !strobe_idle) |=> $stable(state_q));
  assert_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_idle |=> state_q == ST_IDLE);
endmodule

// File: rtl/rbp_data_reg.sv
module rbp_data_reg
  import rbp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rbp_state_e        state_q,
  input  logic              pwr_down,
  input  logic              strobe_idle,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  input  logic              radio_rx_valid,
  input  logic [DATA_W-1:0] radio_rx_data,
  input  logic              radio_tx_req,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              dma_q,
  output logic              ev_accept,
  output logic              ev_ovf,
  output logic              ev_unf
);
  logic active, in_rx, in_tx;
  logic ev_consume, wr_take, rd_take;

  always_comb begin
    active     = !pwr_down && !strobe_idle;
    in_rx      = (state_q == ST_RX);
    in_tx      = (state_q == ST_TX);
    ev_accept  = active && in_rx && radio_rx_valid && (!valid_q || bus_rd_en);
    ev_ovf     = active && in_rx && radio_rx_valid && valid_q && !bus_rd_en;
    ev_consume = active && in_tx && radio_tx_req && valid_q;
    ev_unf     = active && in_tx && radio_tx_req && !valid_q;
    wr_take    = active && in_tx && bus_wr_en && !ev_unf;
    rd_take    = active && in_rx && bus_rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      dma_q <= ev_accept;
      if (pwr_down) begin
        data_q  <= '0;
        valid_q <= 1'b0;
      end else if (strobe_idle) begin
        valid_q <= 1'b0;
      end else begin
        if (ev_accept)    data_q <= radio_rx_data;
        else if (wr_take) data_q <= bus_wdata;
        if (ev_accept || wr_take)      valid_q <= 1'b1;
        else if (rd_take || ev_consume) valid_q <= 1'b0;
      end
    end
  end

  assert_accept_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> valid_q);
  assert_consume_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_consume && !bus_wr_en) |=> !valid_q);
  assert_frozen_in_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_error(state_q) && !pwr_down) |=> $stable(data_q));
  assert_dma_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> dma_q);
  assert_powerdown_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (data_q == '0) && !valid_q);
endmodule

// File: rtl/rbp_irq_ctrl.sv
module rbp_irq_ctrl
  import rbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ovf,
  input  logic              ev_unf,
  input  logic [FLAG_W-1:0] src_evt,
  input  logic              flag_clr_en,
  input  logic [FLAG_W-1:0] flag_clr_data,
  input  logic              mask_wr_en,
  input  logic [FLAG_W-1:0] mask_wdata,
  output logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] mask_q,
  output logic              irq
);
  logic [FLAG_W-1:0] set_vec;

  always_comb begin
    set_vec = src_evt;
    if (ev_ovf) begin
      set_vec[B_RXOVF] = 1'b1;
      set_vec[B_DONE]  = 1'b1;
    end
    if (ev_unf) begin
      set_vec[B_TXUNF] = 1'b1;
      set_vec[B_DONE]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= flag_next(flags_q, flag_clr_en, flag_clr_data, set_vec);
      if (mask_wr_en) mask_q <= mask_wdata;
    end
  end

  assign irq = irq_reduce(flags_q, mask_q);

  for (genvar b = 0; b < FLAG_W; b++) begin : g_sticky
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[b] && !(flag_clr_en && !flag_clr_data[b])) |=> flags_q[b]);
  end
  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_en |=> $stable(mask_q));
  assert_unf_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> flags_q[B_TXUNF] && flags_q[B_DONE]);
  assert_ovf_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> flags_q[B_RXOVF] && flags_q[B_DONE]);
endmodule

// File: rtl/radio_byte_port.sv
module radio_byte_port
  import rbp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              mask_wr_en,
  input  logic [FLAG_W-1:0] mask_wdata,
  input  logic              flag_clr_en,
  input  logic [FLAG_W-1:0] flag_clr_data,
  input  logic              strobe_rx,
  input  logic              strobe_tx,
  input  logic              strobe_idle,
  input  logic              radio_rx_valid,
  input  logic [DATA_W-1:0] radio_rx_data,
  input  logic              radio_tx_req,
  output logic [DATA_W-1:0] radio_tx_data,
  input  logic [FLAG_W-1:0] src_evt,
  output logic [2:0]        state,
  output logic              byte_valid,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] mask,
  output logic              irq,
  output logic              dma_trig
);
  rbp_state_e        state_q;
  logic [DATA_W-1:0] data_q;
  logic              ev_accept, ev_ovf, ev_unf;

  rbp_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .strobe_rx(strobe_rx), .strobe_tx(strobe_tx), .strobe_idle(strobe_idle),
    .ev_ovf(ev_ovf), .ev_unf(ev_unf), .state_q(state_q)
  );

  rbp_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .state_q(state_q),
    .pwr_down(pwr_down), .strobe_idle(strobe_idle),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
    .radio_rx_valid(radio_rx_valid), .radio_rx_data(radio_rx_data),
    .radio_tx_req(radio_tx_req),
    .data_q(data_q), .valid_q(byte_valid), .dma_q(dma_trig),
    .ev_accept(ev_accept), .ev_ovf(ev_ovf), .ev_unf(ev_unf)
  );

  rbp_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
    .src_evt(src_evt), .flag_clr_en(flag_clr_en), .flag_clr_data(flag_clr_data),
    .mask_wr_en(mask_wr_en), .mask_wdata(mask_wdata),
    .flags_q(flags), .mask_q(mask), .irq(irq)
  );

  assign bus_rdata     = data_q;
  assign radio_tx_data = data_q;
  assign state         = state_q;

  assert_accept_only_rx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> state_q == ST_RX);
  assert_errors_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_accept, ev_ovf, ev_unf}) <= 1);
endmodule

// File: tb/test_radio_byte_port.sv
module test_radio_byte_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 0, bus_wr_en = 0, bus_rd_en = 0, mask_wr_en = 0, flag_clr_en = 0;
  logic       strobe_rx = 0, strobe_tx = 0, strobe_idle = 0, radio_rx_valid = 0, radio_tx_req = 0;
  logic [7:0] bus_wdata = 0, mask_wdata = 0, flag_clr_data = 0, radio_rx_data = 0, src_evt = 0;
  logic [7:0] bus_rdata, radio_tx_data, flags, mask;
  logic [2:0] state;
  logic       byte_valid, irq, dma_trig;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  int m_st = 0, m_data = 0, m_valid = 0, m_flags = 0, m_mask = 0, m_dma = 0;

  always #5 clk = ~clk;

  radio_byte_port i_radio_byte_port (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .mask_wr_en(mask_wr_en), .mask_wdata(mask_wdata),
    .flag_clr_en(flag_clr_en), .flag_clr_data(flag_clr_data),
    .strobe_rx(strobe_rx), .strobe_tx(strobe_tx), .strobe_idle(strobe_idle),
    .radio_rx_valid(radio_rx_valid), .radio_rx_data(radio_rx_data),
    .radio_tx_req(radio_tx_req), .radio_tx_data(radio_tx_data), .src_evt(src_evt),
    .state(state), .byte_valid(byte_valid), .flags(flags), .mask(mask),
    .irq(irq), .dma_trig(dma_trig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_data = 0; m_valid = 0; m_flags = 0; m_mask = 0; m_dma = 0;
    end else begin
      bit act, acc, ovf, unf, cons, wr_ok, rd_ok;
      act   = !pwr_down && !strobe_idle;
      acc   = act && m_st == 1 && radio_rx_valid && (m_valid == 0 || bus_rd_en);
      ovf   = act && m_st == 1 && radio_rx_valid && m_valid == 1 && !bus_rd_en;
      cons  = act && m_st == 2 && radio_tx_req && m_valid == 1;
      unf   = act && m_st == 2 && radio_tx_req && m_valid == 0;
      wr_ok = act && m_st == 2 && bus_wr_en && !unf;
      rd_ok = act && m_st == 1 && bus_rd_en;
      m_dma = acc;
      if (pwr_down) begin m_data = 0; m_valid = 0; end
      else if (strobe_idle) m_valid = 0;
      else begin
        if (acc) begin m_data = radio_rx_data; m_valid = 1; end
        else begin
          if (rd_ok || cons) m_valid = 0;
          if (wr_ok) begin m_data = bus_wdata; m_valid = 1; end
        end
      end
      if (strobe_idle) m_st = 0;
      else if (ovf) m_st = 3;
      else if (unf) m_st = 4;
      else if (m_st < 3) begin
        if (strobe_rx) m_st = 1;
        else if (strobe_tx) m_st = 2;
      end
      if (flag_clr_en) m_flags = m_flags & flag_clr_data;
      m_flags = m_flags | src_evt | (ovf ? 8'h50 : 0) | (unf ? 8'h90 : 0);
      if (mask_wr_en) m_mask = mask_wdata;
    end
  end

  // compare every cycle, after the edge has settled
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R1 R2 R9 data", bus_rdata, m_data);
      chk("R2 tx_data", radio_tx_data, m_data);
      chk("R3 R4 R5 R10 state", state, m_st);
      chk("R1 R5 R9 valid", byte_valid, m_valid);
      chk("R3 R4 R7 flags", flags, m_flags);
      chk("R6 mask", mask, m_mask);
      chk("R6 irq", irq, (m_flags & m_mask) != 0);
      chk("R8 dma", dma_trig, m_dma);
    end
  end

  task automatic tick;
    @(posedge clk); #3;
    {pwr_down, bus_wr_en, bus_rd_en, mask_wr_en, flag_clr_en} = '0;
    {strobe_rx, strobe_tx, strobe_idle, radio_rx_valid, radio_tx_req} = '0;
    src_evt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    chk("R6 reset mask", mask, 0);
    chk("R5 reset state", state, 0);
    chk("R7 reset flags", flags, 0);
    chk("R1 reset valid", byte_valid, 0);
    strobe_rx = 1; strobe_tx = 1; tick;
    chk("R10 rx wins", state, 1);
    radio_rx_valid = 1; radio_rx_data = 8'hA5; tick;
    chk("R1 load", bus_rdata, 8'hA5);
    chk("R8 pulse", dma_trig, 1);
    tick;
    chk("R8 pulse ends", dma_trig, 0);
    radio_rx_valid = 1; radio_rx_data = 8'h3C; tick;
    chk("R3 overflow state", state, 3);
    chk("R3 overflow flags", flags, 8'h50);
    chk("R3 byte kept", bus_rdata, 8'hA5);
    radio_rx_valid = 1; radio_rx_data = 8'h11; strobe_tx = 1; tick;
    chk("R5 ignored state", state, 3);
    chk("R5 ignored data", bus_rdata, 8'hA5);
    mask_wr_en = 1; mask_wdata = 8'h40; tick;
    chk("R6 irq on", irq, 1);
    flag_clr_en = 1; flag_clr_data = 8'hBF; tick;
    chk("R7 cleared", flags, 8'h10);
    chk("R6 irq off", irq, 0);
    strobe_idle = 1; tick;
    chk("R5 idle", state, 0);
    chk("R5 idle valid", byte_valid, 0);
    strobe_tx = 1; tick;
    bus_wr_en = 1; bus_wdata = 8'h5A; tick;
    chk("R2 offer", radio_tx_data, 8'h5A);
    radio_tx_req = 1; tick;
    chk("R2 consumed", byte_valid, 0);
    radio_tx_req = 1; bus_wr_en = 1; bus_wdata = 8'h77; tick;
    chk("R4 underflow", state, 4);
    chk("R4 flags", flags, 8'h90);
    chk("R4 write dropped", bus_rdata, 8'h5A);
    pwr_down = 1; tick;
    chk("R9 cleared", bus_rdata, 0);
    chk("R9 state kept", state, 4);
    strobe_idle = 1; tick;
    for (int i = 0; i < 4000; i++) begin
      pwr_down       = ($urandom % 60) == 0;
      bus_wr_en      = ($urandom % 3) == 0;
      bus_wdata      = 8'($urandom);
      bus_rd_en      = ($urandom % 3) == 0;
      radio_rx_valid = ($urandom % 3) == 0;
      radio_rx_data  = 8'($urandom);
      radio_tx_req   = ($urandom % 4) == 0;
      strobe_rx      = ($urandom % 20) == 0;
      strobe_tx      = ($urandom % 20) == 0;
      strobe_idle    = ($urandom % 30) == 0;
      mask_wr_en     = ($urandom % 20) == 0;
      mask_wdata     = 8'($urandom);
      flag_clr_en    = ($urandom % 12) == 0;
      flag_clr_data  = 8'($urandom);
      src_evt        = (($urandom % 20) == 0) ? 8'($urandom) & 8'h3F : 8'h00;
      tick;
    end
    tick;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule